// File: doc/BRIEF.md
# Dynamically obfuscated secure scan chain

This block is a parameterized scan chain that guards a cipher core's state against being read out through test access. Between every pair of neighbouring scan cells sits a 2:1 link selector. It forwards either the true data from the upstream cell or a scrambled copy of it. Each link has its own select bit, formed as the XOR of three inputs: one bit of a random word, one bit of an internal state latch, and one bit of an authentication word. A tester that supplies the right authentication word drives every select to "true". The chain then shifts like an ordinary scan chain. Any other word makes the shifted-out data scrambled, and the scrambling changes over time.

The state latches reload from the chain itself. This happens whenever, during scan, three tapped cells together hold a preset 3-bit key. At that point every latch copies the cell that feeds its link. As a result, the scrambling pattern depends on the data an attacker shifts in. The random word comes from outside the block and is expected to change every clock. In functional mode each cell loads its functional input and the links play no part.

Top module: `obf_scan_chain`

## Requirements
- R1: A synchronous active-low reset clears every scan cell and every state latch to 0 at the next clock edge.
- R2: While `scan_en` is 0, every cell loads its bit of `func_d` at each clock edge, and link selects have no effect.
- R3: While `scan_en` is 1, cell 0 loads `scan_in` at each clock edge.
- R4: The select for link i, which feeds cell i+1 from cell i, is `rnd_word[i] ^ state_latch[i] ^ auth_word[i]`. A select of 1 makes cell i+1 load the previous value of cell i during scan.
- R5: With `OBF_MODE` = feedback-XOR and a select of 0, cell i+1 loads cell i XOR cell i-1 XOR cell i+2. Any cell index outside the chain counts as 0.
- R6: With `OBF_MODE` = invert and a select of 0, cell i+1 loads the inverse of cell i.
- R7: The key-match check is evaluated only when `scan_en` is 1. It compares the concatenation {cell[TAP_HI], cell[TAP_MID], cell[TAP_LO]}, with TAP_HI as the MSB, against `KEY` (default 3'b011). On a match, latch j loads cell j at that edge, for every j from 0 to N_CELLS-2, using the cell values from before the shift.
- R8: When there is no key match, or when `scan_en` is 0, every state latch keeps its value.
- R9: `scan_out` always equals the last cell. `func_q` always presents all cells, with bit k equal to cell k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_en | input | 1 | 1 selects shift mode, 0 selects functional capture |
| scan_in | input | 1 | Serial data into cell 0 |
| func_d | input | N_CELLS | Functional data, one bit per cell |
| rnd_word | input | N_CELLS-1 | Random bits, one per link |
| auth_word | input | N_CELLS-1 | Authentication bits, one per link |
| func_q | output | N_CELLS | Present value of every cell |
| scan_out | output | 1 | Last cell of the chain |

## Verification
The bench builds two 16-cell chains, one for each scrambling mode, with the key taps at cells 12, 7 and 2. This short length lets a shifted pattern travel the whole chain within a few cycles. It also makes loaded patterns that hit or miss the key easy to construct, so latch reloads can be forced or avoided on purpose. A behavioural model tracks each chain and its latches. The bench computes authentication words from that model so that it can switch between a clean chain and an obfuscated one. A serial-delay check confirms that an authenticated chain returns its input unchanged after exactly 16 shifts.

// File: rtl/obf_scan_pkg.sv
// Package: shared types for the obfuscated scan chain.
// Assumes nothing; holds only the obfuscation mode enumeration.
package obf_scan_pkg;

    // Which scrambled value a link forwards when its select is 0.
    typedef enum logic {
        OBF_XOR_FB = 1'b0,  // upstream XOR two neighbours
        OBF_INVERT = 1'b1   // upstream inverted
    } obf_mode_e;

endpackage

// File: rtl/obf_link.sv
// Module: obf_link
// One 2:1 selector between two scan cells. A select of 1 forwards the
// upstream cell. A select of 0 forwards a scrambled value chosen by MODE.
// Assumes the caller ties out-of-range neighbour taps to 0.
module obf_link
    import obf_scan_pkg::*;
#(
    parameter obf_mode_e MODE = OBF_XOR_FB
) (
    input  logic prev_q,
    input  logic back_q,
    input  logic fwd_q,
    input  logic sel_true,
    output logic link_d
);

    logic scrambled;

    generate
        if (MODE == OBF_XOR_FB) begin : g_xor
            // Double-feedback scramble from the two neighbours.
            assign scrambled = prev_q ^ back_q ^ fwd_q;
        end else begin : g_inv
            logic unused_taps;
            // Plain inversion; neighbour taps are not needed.
            assign unused_taps = back_q ^ fwd_q;
            assign scrambled   = ~prev_q;
        end
    endgenerate

    // Pick true or scrambled data for the downstream cell.
    assign link_d = sel_true ? prev_q : scrambled;

endmodule

// File: rtl/obf_key_match.sv
// Module: obf_key_match
// Compares three tapped cell bits with the preset key.
// Assumes the taps arrive as {high, mid, low}. A hit is reported only in scan mode.
module obf_key_match #(
    parameter logic [2:0] KEY = 3'b011
) (
    input  logic       scan_en,
    input  logic [2:0] taps,
    output logic       hit
);

    // Qualify the pattern compare with scan mode.
    assign hit = scan_en && (taps == KEY);

endmodule

// File: rtl/obf_state_latch.sv
// Module: obf_state_latch
// Bank of state-dependent select latches. All of them load in parallel
// from the scan cells when load is high and hold otherwise.
// Assumes a synchronous active-low reset.
module obf_state_latch #(
    parameter int N_LAT = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [N_LAT-1:0] cap,
    output logic [N_LAT-1:0] lat_q
);

    // Clear on reset, capture cell state on a key hit, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    lat_q <= '0;
        else if (load) lat_q <= cap;
    end

endmodule

// File: rtl/obf_scan_chain.sv
// Module: obf_scan_chain (top)
// Scan chain of N_CELLS cells with an obfuscating selector on every link.
// Link i feeds cell i+1 from cell i. Its select is the XOR of the random,
// state-latch and authentication bits. Assumes the tap positions lie
// inside the chain and N_CELLS >= 3.
module obf_scan_chain
    import obf_scan_pkg::*;
#(
    parameter int         N_CELLS  = 128,
    parameter int         TAP_HI   = 10,
    parameter int         TAP_MID  = 63,
    parameter int         TAP_LO   = 120,
    parameter logic [2:0] KEY      = 3'b011,
    parameter obf_mode_e  OBF_MODE = OBF_XOR_FB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scan_en,
    input  logic               scan_in,
    input  logic [N_CELLS-1:0] func_d,
    input  logic [N_CELLS-2:0] rnd_word,
    input  logic [N_CELLS-2:0] auth_word,
    output logic [N_CELLS-1:0] func_q,
    output logic               scan_out
);

    localparam int N_LINKS = N_CELLS - 1;

    logic [N_CELLS-1:0] cell_q;
    logic [N_CELLS-1:0] shift_d;
    logic [N_LINKS-1:0] lat_q;
    logic [N_LINKS-1:0] link_sel;
    logic               key_hit;

    // Three-way select per link.
    assign link_sel   = rnd_word ^ lat_q ^ auth_word;
    assign shift_d[0] = scan_in;

    genvar gi;
    generate
        for (gi = 1; gi < N_CELLS; gi++) begin : g_link
            logic back_tap;
            logic fwd_tap;
            if (gi >= 2) begin : g_back
                assign back_tap = cell_q[gi-2];
            end else begin : g_back0
                assign back_tap = 1'b0;
            end
            if (gi < N_CELLS - 1) begin : g_fwd
                assign fwd_tap = cell_q[gi+1];
            end else begin : g_fwd0
                assign fwd_tap = 1'b0;
            end
            obf_link #(.MODE(OBF_MODE)) u_link (
                .prev_q  (cell_q[gi-1]),
                .back_q  (back_tap),
                .fwd_q   (fwd_tap),
                .sel_true(link_sel[gi-1]),
                .link_d  (shift_d[gi])
            );
        end
    endgenerate

    obf_key_match #(.KEY(KEY)) u_match (
        .scan_en(scan_en),
        .taps   ({cell_q[TAP_HI], cell_q[TAP_MID], cell_q[TAP_LO]}),
        .hit    (key_hit)
    );

    obf_state_latch #(.N_LAT(N_LINKS)) u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .load (key_hit),
        .cap  (cell_q[N_LINKS-1:0]),
        .lat_q(lat_q)
    );

    // Scan cells: clear, shift through the links, or take functional data.
    always_ff @(posedge clk) begin
        if (!rst_n)       cell_q <= '0;
        else if (scan_en) cell_q <= shift_d;
        else              cell_q <= func_d;
    end

    assign func_q   = cell_q;
    assign scan_out = cell_q[N_CELLS-1];

endmodule

// File: rtl/obf_scan_chain_chk.sv
// Module: obf_scan_chain_chk
// Temporal checks on the chain, attached to every obf_scan_chain by bind.
// Assumes access to the cell register and the latch bank.
module obf_scan_chain_chk
    import obf_scan_pkg::*;
#(
    parameter int         N_CELLS  = 128,
    parameter int         TAP_HI   = 10,
    parameter int         TAP_MID  = 63,
    parameter int         TAP_LO   = 120,
    parameter logic [2:0] KEY      = 3'b011,
    parameter obf_mode_e  OBF_MODE = OBF_XOR_FB
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scan_en,
    input logic               scan_in,
    input logic [N_CELLS-1:0] func_d,
    input logic [N_CELLS-2:0] rnd_word,
    input logic [N_CELLS-2:0] auth_word,
    input logic [N_CELLS-1:0] cells,
    input logic [N_CELLS-2:0] lats
);

    localparam int NL = N_CELLS - 1;

    logic [NL-1:0] sel_w;
    logic          hit_w;

    // Independent view of the selects and the key hit.
    assign sel_w = rnd_word ^ lats ^ auth_word;
    assign hit_w = scan_en && ({cells[TAP_HI], cells[TAP_MID], cells[TAP_LO]} == KEY);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (cells == '0 && lats == '0));

    a_r2_func_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> cells == $past(func_d));

    a_r3_scan_head: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> cells[0] == $past(scan_in));

    a_r4_clean_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && (&sel_w)) |=> cells[NL:1] == $past(cells[NL-1:0]));

    generate
        if (OBF_MODE == OBF_XOR_FB) begin : g_xor_chk
            a_r5_xor_first_link: assert property (@(posedge clk) disable iff (!rst_n)
                (scan_en && !sel_w[0]) |=> cells[1] == $past(cells[0] ^ cells[2]));
        end else begin : g_inv_chk
            a_r6_invert_all: assert property (@(posedge clk) disable iff (!rst_n)
                (scan_en && sel_w == '0) |=> cells[NL:1] == ~$past(cells[NL-1:0]));
        end
    endgenerate

    a_r7_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        hit_w |=> lats == $past(cells[NL-1:0]));

    a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_w |=> $stable(lats));

endmodule

bind obf_scan_chain obf_scan_chain_chk #(
    .N_CELLS (N_CELLS),
    .TAP_HI  (TAP_HI),
    .TAP_MID (TAP_MID),
    .TAP_LO  (TAP_LO),
    .KEY     (KEY),
    .OBF_MODE(OBF_MODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_en  (scan_en),
    .scan_in  (scan_in),
    .func_d   (func_d),
    .rnd_word (rnd_word),
    .auth_word(auth_word),
    .cells    (cell_q),
    .lats     (lat_q)
);

// File: tb/test_obf_scan_chain.sv
// Bench: two 16-cell chains (feedback-XOR and invert) compared against a
// behavioural model after every clock.
module test_obf_scan_chain;
    import obf_scan_pkg::*;

    localparam int N  = 16;
    localparam int NL = N - 1;
    localparam int TH = 12;
    localparam int TM = 7;
    localparam int TL = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n   = 1'b0;
    logic          scan_en = 1'b0;
    logic          scan_in = 1'b0;
    logic [N-1:0]  func_d  = '0;
    logic [NL-1:0] rnd0 = '0, rnd1 = '0, auth0 = '0, auth1 = '0;
    logic [N-1:0]  fq0, fq1;
    logic          so0, so1;

    int checks = 0;
    int errors = 0;

    logic [N-1:0]  mq [2];
    logic [NL-1:0] ml [2];

    obf_scan_chain #(.N_CELLS(N), .TAP_HI(TH), .TAP_MID(TM), .TAP_LO(TL),
                     .KEY(3'b011), .OBF_MODE(OBF_XOR_FB)) i_obf_scan_chain (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
        .func_d(func_d), .rnd_word(rnd0), .auth_word(auth0),
        .func_q(fq0), .scan_out(so0));

    obf_scan_chain #(.N_CELLS(N), .TAP_HI(TH), .TAP_MID(TM), .TAP_LO(TL),
                     .KEY(3'b011), .OBF_MODE(OBF_INVERT)) i_obf_scan_chain_inv (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
        .func_d(func_d), .rnd_word(rnd1), .auth_word(auth1),
        .func_q(fq1), .scan_out(so1));

    // Behavioural next state of chain k from the requirements.
    task automatic model_edge(int k, logic [NL-1:0] rnd, logic [NL-1:0] au);
        logic [N-1:0]  nq;
        logic [NL-1:0] nl;
        logic s, ob, b2, fw;
        if (!rst_n) begin
            mq[k] = '0;
            ml[k] = '0;
            return;
        end
        nl = ml[k];
        if (scan_en && !mq[k][TH] && mq[k][TM] && mq[k][TL]) nl = mq[k][NL-1:0];
        if (scan_en) begin
            nq[0] = scan_in;
            for (int i = 1; i < N; i++) begin
                s  = rnd[i-1] ^ ml[k][i-1] ^ au[i-1];
                b2 = (i >= 2) ? mq[k][i-2] : 1'b0;
                fw = (i < N-1) ? mq[k][i+1] : 1'b0;
                ob = (k == 1) ? ~mq[k][i-1] : (mq[k][i-1] ^ b2 ^ fw);
                nq[i] = s ? mq[k][i-1] : ob;
            end
        end else begin
            nq = func_d;
        end
        mq[k] = nq;
        ml[k] = nl;
    endtask

    task automatic check_vec(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: update the model at the edge, compare away from it.
    task automatic step(string tag);
        @(posedge clk);
        model_edge(0, rnd0, auth0);
        model_edge(1, rnd1, auth1);
        @(negedge clk);
        check_vec(tag, "xor chain cells", fq0, mq[0]);
        check_vec(tag, "inv chain cells", fq1, mq[1]);
        check_vec("R9", "scan_out pair", {{(N-2){1'b0}}, so1, so0},
                  {{(N-2){1'b0}}, mq[1][N-1], mq[0][N-1]});
    endtask

    // Authentication words that force every select to 1 (R4).
    task automatic authenticate();
        auth0 = ~(rnd0 ^ ml[0]);
        auth1 = ~(rnd1 ^ ml[1]);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic q_in[$];
        logic exp_bit;
        @(negedge clk);
        // R1: reset state.
        for (int c = 0; c < 3; c++) step("R1");
        rst_n = 1'b1;

        // R2: functional capture under varied data, links irrelevant.
        for (int c = 0; c < 6; c++) begin
            func_d = N'($urandom);
            rnd0 = NL'($urandom); rnd1 = NL'($urandom);
            auth0 = NL'($urandom); auth1 = NL'($urandom);
            step("R2");
        end

        // R4 / R3: authenticated shifting returns scan_in after N shifts.
        scan_en = 1'b1;
        for (int c = 0; c < 3 * N; c++) begin
            rnd0 = NL'($urandom); rnd1 = NL'($urandom);
            authenticate();
            scan_in = 1'($urandom);
            q_in.push_back(scan_in);
            step("R4");
            if (q_in.size() == N) begin
                exp_bit = q_in.pop_front();
                check_vec("R4", "clean serial delay",
                          {{(N-2){1'b0}}, so1, so0}, {{(N-2){1'b0}}, exp_bit, exp_bit});
            end
        end

        // R5 / R6: obfuscated shifting with random selects.
        for (int c = 0; c < 40; c++) begin
            rnd0 = NL'($urandom); rnd1 = NL'($urandom);
            auth0 = '0; auth1 = '0;
            scan_in = 1'($urandom);
            step((c % 2) ? "R6" : "R5");
        end

        // R7: load a key-matching pattern, then shift once to reload latches.
        scan_en = 1'b0;
        func_d = N'($urandom);
        func_d[TH] = 1'b0; func_d[TM] = 1'b1; func_d[TL] = 1'b1;
        step("R2");
        scan_en = 1'b1;
        rnd0 = '0; rnd1 = '0; auth0 = '0; auth1 = '0;
        for (int c = 0; c < 8; c++) begin
            scan_in = 1'($urandom);
            step("R7");
        end

        // R8: functional loads that match the key must not touch latches.
        scan_en = 1'b0;
        for (int c = 0; c < 3; c++) begin
            func_d = N'($urandom);
            func_d[TH] = 1'b0; func_d[TM] = 1'b1; func_d[TL] = 1'b1;
            step("R8");
        end
        // R8: a non-matching pattern shifted keeps the latches.
        func_d = N'($urandom);
        func_d[TH] = 1'b1;
        step("R2");
        scan_en = 1'b1;
        for (int c = 0; c < 6; c++) begin
            scan_in = 1'b1;
            step("R8");
        end

        // R1: reset in the middle of activity.
        rst_n = 1'b0;
        step("R1");
        rst_n = 1'b1;

        // Mixed random run covering all modes.
        for (int c = 0; c < 300; c++) begin
            scan_en = ($urandom % 5) != 0;
            scan_in = 1'($urandom);
            func_d = N'($urandom);
            rnd0 = NL'($urandom); rnd1 = NL'($urandom);
            if ($urandom % 2) authenticate();
            else begin auth0 = NL'($urandom); auth1 = NL'($urandom); end
            step(scan_en ? "R3" : "R2");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule